// File: doc/BRIEF.md
# Serial Bit-Rate and Frame Format Generator

This block serves one serial channel. It takes the channel's mode byte, its transmit-control and receive-control bytes and a two-byte time constant, and from them it produces two things. The first is a single-cycle bit-time tick. The second is the decoded character format: parity on or off, even or odd parity, the number of data bits and the number of stop bits. The transmit and receive shifters that use these outputs are outside this block.

The tick comes from a 16-bit down-counter followed by a prescaler. The counter steps once for each pulse on the reference enable. Its period is the time constant plus two reference pulses. The prescaler then divides by 1, 16, 32 or 64. With a 2.4576 MHz reference, a time constant of 0 gives 1,228,800 counter periods per second before the prescale divide.

Software writes the configuration one byte at a time through an address/data strobe. A write that changes the rate restarts the divider chain straight away, so the old period does not have to run out first.

Top module: `serial_rate_gen`

## Requirements
- R1: After reset the mode byte is 0x04 and the time constant, transmit-control and receive-control bytes are all zero. The outputs then show parity off, odd parity, one stop bit and 5 data bits, and no tick is given.
- R2: The time constant is {high byte (address 4), low byte (address 3)}. With a prescale of 1 the tick period is (time constant + 2) reference-enable pulses.
- R3: Mode byte (address 0) bits 7:6 select the prescale divide: 00 gives 1, 01 gives 16, 10 gives 32 and 11 gives 64. The tick period is (time constant + 2) × divide reference pulses.
- R4: Mode bit 0 turns parity on. While parity is on, mode bit 1 = 1 selects even parity and 0 selects odd. The even/odd output reads 0 while parity is off.
- R5: Mode bits 3:2 = 11 give two stop bits. Every other value gives one stop bit.
- R6: Transmit-control (address 1) bits 6:5 set the data length: 00 gives 5 bits, 01 gives 7, 10 gives 6 and 11 gives 8.
- R7: A write to the mode byte or to either time-constant byte reloads the counter and clears the prescaler. With the reference enable held high and a prescale of 1, the first tick is seen in the cycle that follows the (time constant + 3)-th rising edge after the write edge.
- R8: The tick lasts one clock cycle. It appears only while transmit-control bit 3 (transmit enable) or receive-control (address 2) bit 0 (receive enable) is set.
- R9: The counter advances only on clock cycles in which the reference enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_en | input | 1 | One-cycle pulse per reference clock period |
| wr_stb | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 mode, 1 tx control, 2 rx control, 3 tc low, 4 tc high) |
| wr_data | input | 8 | Register write data |
| bit_tick | output | 1 | One-cycle pulse per bit time |
| par_en | output | 1 | Parity enabled |
| par_even | output | 1 | Even parity selected (valid with par_en) |
| two_stop | output | 1 | Two stop bits selected |
| data_bits | output | 4 | Data length in bits (5 to 8) |

## Verification
The hardest case to reach from the ports is a reload in the middle of a period. The write must land while the counter still holds a value from the old time constant, and the first tick after it must follow the new constant at an exact cycle offset. The bench first runs a long period, then writes a short constant partway through, then counts rising edges from the write edge to the first tick. A divided reference enable (one pulse in three clocks) shows that the counter steps only on reference pulses.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;

  localparam int REG_AW = 3;
  localparam int REG_DW = 8;
  localparam int TC_W   = 2 * REG_DW;
  localparam int PS_W   = 6;

  localparam logic [REG_AW-1:0] A_MODE  = 3'd0;
  localparam logic [REG_AW-1:0] A_TXCTL = 3'd1;
  localparam logic [REG_AW-1:0] A_RXCTL = 3'd2;
  localparam logic [REG_AW-1:0] A_TC_LO = 3'd3;
  localparam logic [REG_AW-1:0] A_TC_HI = 3'd4;

  localparam logic [REG_DW-1:0] MODE_RST = 8'h04;

  typedef enum logic [1:0] {PS_DIV1, PS_DIV16, PS_DIV32, PS_DIV64} prescale_e;

  typedef struct packed {
    logic       par_en;
    logic       par_even;
    logic       two_stop;
    logic [3:0] data_bits;
  } frame_cfg_t;

  // Last prescaler count value for a given divide selection
  function automatic logic [PS_W-1:0] ps_last(prescale_e sel);
    case (sel)
      PS_DIV1:  ps_last = 6'd0;
      PS_DIV16: ps_last = 6'd15;
      PS_DIV32: ps_last = 6'd31;
      default:  ps_last = 6'd63;
    endcase
  endfunction

  // Data length code: note 01 -> 7 and 10 -> 6
  function automatic logic [3:0] len_decode(logic [1:0] code);
    case (code)
      2'b00:   len_decode = 4'd5;
      2'b01:   len_decode = 4'd7;
      2'b10:   len_decode = 4'd6;
      default: len_decode = 4'd8;
    endcase
  endfunction

  // Counter start value: period is tc + 2 reference pulses
  function automatic logic [TC_W:0] reload_val(logic [TC_W-1:0] tc);
    reload_val = {1'b0, tc} + {{TC_W{1'b0}}, 1'b1};
  endfunction

endpackage

// File: rtl/ser_cfg_regs.sv
module ser_cfg_regs
  import ser_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  output logic [REG_DW-1:0] mode_q,
  output logic [REG_DW-1:0] txctl_q,
  output logic [REG_DW-1:0] rxctl_q,
  output logic [TC_W-1:0]   tc_q,
  output logic              load_o
);

  logic rate_hit;
  assign rate_hit = (wr_addr == A_MODE) || (wr_addr == A_TC_LO) || (wr_addr == A_TC_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_RST;
      txctl_q <= '0;
      rxctl_q <= '0;
      tc_q    <= '0;
      load_o  <= 1'b0;
    end else begin
      load_o <= wr_stb && rate_hit;
      if (wr_stb) begin
        case (wr_addr)
          A_MODE:  mode_q  <= wr_data;
          A_TXCTL: txctl_q <= wr_data;
          A_RXCTL: rxctl_q <= wr_data;
          A_TC_LO: tc_q[REG_DW-1:0]    <= wr_data;
          A_TC_HI: tc_q[TC_W-1:REG_DW] <= wr_data;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/ser_tc_counter.sv
module ser_tc_counter
  import ser_cfg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_en,
  input  logic            load,
  input  logic [TC_W-1:0] tc,
  output logic            base_o
);

  logic [TC_W:0] cnt_q;
  logic          cnt_zero;
  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= reload_val('0);
      base_o <= 1'b0;
    end else if (load) begin
      cnt_q  <= reload_val(tc);
      base_o <= 1'b0;
    end else begin
      base_o <= ref_en && cnt_zero;
      if (ref_en) cnt_q <= cnt_zero ? reload_val(tc) : cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/ser_prescale.sv
module ser_prescale
  import ser_cfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  logic      base,
  input  prescale_e sel,
  output logic      tick_o
);

  logic [PS_W-1:0] pcnt_q;
  logic            at_last;
  assign at_last = (pcnt_q == ps_last(sel));
  assign tick_o  = base && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (load)    pcnt_q <= '0;
    else if (base)    pcnt_q <= at_last ? '0 : pcnt_q + 1'b1;
  end

endmodule

// File: rtl/ser_frame_dec.sv
module ser_frame_dec
  import ser_cfg_pkg::*;
(
  input  logic [REG_DW-1:0] mode,
  input  logic [REG_DW-1:0] txctl,
  output frame_cfg_t        frame
);

  always_comb begin
    frame.par_en    = mode[0];
    frame.par_even  = mode[0] & mode[1];
    frame.two_stop  = (mode[3:2] == 2'b11);
    frame.data_bits = len_decode(txctl[6:5]);
  end

endmodule

// File: rtl/serial_rate_gen.sv
module serial_rate_gen
  import ser_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic              wr_stb,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  output logic              bit_tick,
  output logic              par_en,
  output logic              par_even,
  output logic              two_stop,
  output logic [3:0]        data_bits
);

  logic [REG_DW-1:0] mode_q, txctl_q, rxctl_q;
  logic [TC_W-1:0]   tc_q;
  logic              load_pulse;
  logic              base_pulse;
  logic              pre_tick;
  logic              line_on;
  frame_cfg_t        frame;

  ser_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_q(mode_q), .txctl_q(txctl_q), .rxctl_q(rxctl_q), .tc_q(tc_q), .load_o(load_pulse)
  );

  ser_tc_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .load(load_pulse), .tc(tc_q), .base_o(base_pulse)
  );

  ser_prescale u_ps (
    .clk(clk), .rst_n(rst_n), .load(load_pulse), .base(base_pulse),
    .sel(prescale_e'(mode_q[7:6])), .tick_o(pre_tick)
  );

  ser_frame_dec u_dec (.mode(mode_q), .txctl(txctl_q), .frame(frame));

  assign line_on   = txctl_q[3] | rxctl_q[0];
  assign bit_tick  = pre_tick & line_on;
  assign par_en    = frame.par_en;
  assign par_even  = frame.par_even;
  assign two_stop  = frame.two_stop;
  assign data_bits = frame.data_bits;

endmodule

// File: rtl/ser_rate_chk.sv
module ser_rate_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_en,
  input logic wr_stb,
  input logic bit_tick,
  input logic base_pulse,
  input logic load_pulse,
  input logic [3:0] data_bits
);

  p_tick_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);

  p_tick_from_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> base_pulse);

  p_base_on_ref_r9: assert property (@(posedge clk) disable iff (!rst_n)
    base_pulse |-> $past(ref_en));

  p_load_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |-> $past(wr_stb));

  p_no_base_after_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> !base_pulse);

  p_len_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_bits >= 4'd5) && (data_bits <= 4'd8));

endmodule

bind serial_rate_gen ser_rate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .wr_stb(wr_stb), .bit_tick(bit_tick),
  .base_pulse(base_pulse), .load_pulse(load_pulse), .data_bits(data_bits)
);

// File: tb/sim_serial_rate_gen.sv
module sim_serial_rate_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_en = 1'b0;
  logic       wr_stb = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       bit_tick, par_en, par_even, two_stop;
  logic [3:0] data_bits;

  int n_checks = 0;
  int n_errs   = 0;
  int ref_div  = 1;
  int ref_cnt  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  serial_rate_gen u0 (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .bit_tick(bit_tick), .par_en(par_en), .par_even(par_even),
    .two_stop(two_stop), .data_bits(data_bits)
  );

  always @(negedge clk) begin
    ref_en  <= (ref_cnt == 0);
    ref_cnt <= (ref_cnt + 1 >= ref_div) ? 0 : ref_cnt + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic wait_tick(output int waited);
    waited = 0;
    do begin
      @(posedge clk); @(negedge clk);
      waited++;
    end while (!bit_tick && waited < 20000);
  endtask

  task automatic period(output int p);
    int w;
    wait_tick(w);
    wait_tick(p);
  endtask

  task automatic set_tc(input int tc);
    wr(3'd3, tc[7:0]);
    wr(3'd4, tc[15:8]);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 par_en", par_en, 0);
    check("R1 par_even", par_even, 0);
    check("R1 two_stop", two_stop, 0);
    check("R1 data_bits", data_bits, 5);
    begin
      int seen = 0;
      repeat (50) begin @(posedge clk); @(negedge clk); if (bit_tick) seen++; end
      check("R1 no tick while disabled", seen, 0);
    end
  endtask

  task automatic t_gate;
    int p, seen, wide;
    wr(3'd1, 8'h08);
    period(p);
    check("R8 tx enable gives ticks (tc=0 period)", p, 2);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h01);
    period(p);
    check("R8 rx enable gives ticks", p, 2);
    wide = 0;
    repeat (40) begin
      @(posedge clk); @(negedge clk);
      if (bit_tick) begin @(posedge clk); @(negedge clk); if (bit_tick) wide++; end
    end
    check("R8 tick one cycle wide", wide, 0);
    wr(3'd2, 8'h00);
    seen = 0;
    repeat (60) begin @(posedge clk); @(negedge clk); if (bit_tick) seen++; end
    check("R8 no tick with both enables clear", seen, 0);
    wr(3'd2, 8'h01);
  endtask

  task automatic t_rate;
    int p;
    set_tc(16'h0005);
    period(p);
    check("R2 period tc=5", p, 7);
    set_tc(16'h0103);
    period(p);
    check("R2 period tc=0x0103 (high byte upper)", p, 261);
    ref_div = 3;
    set_tc(16'h0004);
    period(p);
    check("R9 period with ref every 3rd cycle", p, 18);
    ref_div = 1;
  endtask

  task automatic t_prescale;
    int p;
    set_tc(16'h0001);
    wr(3'd0, 8'h44); period(p); check("R3 divide 16", p, 3 * 16);
    wr(3'd0, 8'h84); period(p); check("R3 divide 32", p, 3 * 32);
    wr(3'd0, 8'hC4); period(p); check("R3 divide 64", p, 3 * 64);
    wr(3'd0, 8'h04); period(p); check("R3 divide 1", p, 3);
  endtask

  task automatic t_frame;
    wr(3'd0, 8'h07);
    check("R4 parity on", par_en, 1); check("R4 even", par_even, 1);
    wr(3'd0, 8'h05);
    check("R4 odd", par_even, 0); check("R4 parity on odd", par_en, 1);
    wr(3'd0, 8'h06);
    check("R4 parity off", par_en, 0); check("R4 even reads 0 when off", par_even, 0);
    wr(3'd0, 8'h0C); check("R5 two stop", two_stop, 1);
    wr(3'd0, 8'h08); check("R5 one stop (10)", two_stop, 0);
    wr(3'd0, 8'h04); check("R5 one stop (01)", two_stop, 0);
    wr(3'd1, 8'h00); check("R6 code 00", data_bits, 5);
    wr(3'd1, 8'h20); check("R6 code 01", data_bits, 7);
    wr(3'd1, 8'h40); check("R6 code 10", data_bits, 6);
    wr(3'd1, 8'h60); check("R6 code 11", data_bits, 8);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_reload;
    int n;
    set_tc(16'h0200);
    repeat (100) @(posedge clk);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = 3'd4; wr_data = 8'h00;
    @(posedge clk);
    @(negedge clk);
    wr_stb = 1'b0;
    wait_tick(n);
    check("R7 first tick after mid-period reload (tc=0)", n, 3);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = 3'd3; wr_data = 8'h09;
    @(posedge clk);
    @(negedge clk);
    wr_stb = 1'b0;
    wait_tick(n);
    check("R7 first tick after reload (tc=9)", n, 12);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_gate;
    t_rate;
    t_prescale;
    t_frame;
    t_reload;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule